// File: doc/BRIEF.md
# Tuple Chain Walker

This block walks the linked chain of information tuples that a plug-in card keeps in its byte-wide attribute memory, and reports each tuple it finds. A pulse on `start` begins a walk at address zero of attribute space. The walker issues one byte read at a time and waits for each byte to come back before it moves on. For every tuple it reads the type code and the link byte. It then offers the code, the link, the tuple's start address and the memory space on a valid/ready stream. Tuple bodies are not decoded. The only exception is the destination address carried by a long-link tuple.

The chain rules are handled in hardware:
- attribute-space tuples sit on even addresses only;
- null tuples are skipped;
- a chain ends on a termination code or on a link byte of FFh;
- a no-link tuple closes the whole walk;
- a long-link tuple sends the walk to an address in attribute or common memory;
- a chain in attribute space that names neither of these continues at address zero of common memory.

Each jump destination must start with a link-target tuple. A tuple counter stops a chain that loops back on itself. `done` and the two error flags stay set until the next walk starts.

Back-pressure rules:
- Tuple stream: once `tup_valid` is high, it stays high and the code, link, address and space outputs stay constant until a cycle with `tup_ready` high. The transfer happens on that cycle's clock edge, and the walker issues no read while a tuple waits.
- Read interface: a request stays valid with a constant address and space until a cycle with `rd_rsp_valid` high. The byte on `rd_rsp_data` is taken on that edge. `rd_rsp_valid` is ignored while no request is valid. The response may come in the same cycle as the request or any number of cycles later.

Top module: `tuple_walker`

## Requirements
- R1: After reset `busy`, `done`, `link_err`, `limit_err`, `rd_req_valid` and `tup_valid` are low. A `start` pulse while idle begins a walk at attribute address 0 and raises `busy` on the next cycle. A `start` pulse while `busy` is high is ignored.
- R2: A read request keeps `rd_req_valid` high with a constant `rd_req_addr` and `rd_req_common` until the cycle in which `rd_rsp_valid` is high.
- R3: In attribute space (`rd_req_common`=0), byte k of a tuple that starts at A is read from A+2k. The next tuple starts at A+2(2+link). Attribute requests always use even addresses.
- R4: In common space (`rd_req_common`=1), byte k of a tuple that starts at A is read from A+k. The next tuple starts at A+2+link.
- R5: Each tuple other than null, termination and a tuple whose link byte is FFh is offered exactly once on the tuple stream, in chain order:
  - `tup_code` is byte 0 and `tup_link` is byte 1;
  - `tup_addr` and `tup_common` give the start address and space;
  - the outputs are held while `tup_ready` is low.
- R6: Code 00h is a one-byte null tuple. It is not reported, and the next tuple starts at the following byte position.
- R7: A code byte of FFh, or a link byte of FFh, ends the current chain. A tuple with link FFh is not reported.
- R8: If the current chain contained a no-link tuple (code 14h), the walk ends at the end of that chain with `done` and no error. This holds even if a long-link tuple was also seen.
- R9: A long-link tuple (code 11h: attribute destination, code 12h: common destination) carries a little-endian destination address in its first ceil(AW/8) data bytes. When a chain that holds one ends, the walk continues at the destination of the last one in that chain. An attribute destination has bit 0 cleared.
- R10: A chain in attribute space that ends with neither a no-link nor a long-link tuple continues at common address 0. A chain in common space that ends that way completes the walk with no error.
- R11: The first code read after a long-link jump must be 13h, or the walk stops with `link_err` and `done`. After the implied jump to common address 0, a missing 13h ends the walk with `done` and no error. A 13h tuple is reported like any other.
- R12: A walk processes at most MAX_TUPLES code bytes. When one more code byte arrives, the walk stops with `limit_err` and `done`.
- R13: `done`, `link_err` and `limit_err` stay set until the next accepted `start`, which clears them. An error flag is only ever high together with `done`, and at most one error flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Last walk finished (sticky) |
| link_err | output | 1 | Last walk stopped on a missing link target after a long-link jump |
| limit_err | output | 1 | Last walk stopped on the tuple limit |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_addr | output | AW | Byte address of the request |
| rd_req_common | output | 1 | 0: attribute space, 1: common space |
| rd_rsp_valid | input | 1 | Read data present for the pending request |
| rd_rsp_data | input | 8 | Read data byte |
| tup_valid | output | 1 | Tuple report offered |
| tup_ready | input | 1 | Consumer accepts the report |
| tup_code | output | 8 | Tuple type code |
| tup_link | output | 8 | Tuple link value |
| tup_addr | output | AW | Tuple start address |
| tup_common | output | 1 | Tuple space (0 attribute, 1 common) |

## Verification
The bound checker watches the following on every cycle:
- both handshakes hold their request or report stable under back-pressure;
- attribute reads never go to an odd address;
- an error flag only ever appears together with `done`, never two at once;
- nothing is requested or offered outside a walk.

The chain semantics can only be shown by the bench's scenarios, which compare the full report list and the final flags with values computed from the image the bench builds. These cover the address arithmetic in both spaces swept over link values, null skipping, no-link precedence, long-link jumps with forced even destinations, the implied jump, the quiet and the faulting link-target misses, link FFh, the looping chain caught by the limit, and a restart ignored mid-walk.

// File: rtl/twalk_pkg.sv
package twalk_pkg;

  // tuple codes whose values the walker acts on
  localparam logic [7:0] TC_NULL     = 8'h00;
  localparam logic [7:0] TC_LL_ATTR  = 8'h11;
  localparam logic [7:0] TC_LL_COM   = 8'h12;
  localparam logic [7:0] TC_TARGET   = 8'h13;
  localparam logic [7:0] TC_NOLINK   = 8'h14;
  localparam logic [7:0] TC_END      = 8'hFF;
  localparam logic [7:0] LINK_END    = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CODE,
    ST_LINK,
    ST_SEND,
    ST_DEST
  } walk_state_e;

endpackage

// File: rtl/tw_addr_step.sv
// Adds a byte offset to a tuple base: doubled in attribute space, plain in common space.
module tw_addr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic          is_common,
  input  logic [8:0]    off,
  output logic [AW-1:0] addr
);
  logic [9:0] scaled;

  assign scaled = is_common ? {1'b0, off} : {off, 1'b0};
  assign addr   = base + AW'(scaled);
endmodule

// File: rtl/tw_visit_guard.sv
// Counts code bytes consumed in one walk and flags when the budget is spent.
module tw_visit_guard #(
  parameter int MAX_TUPLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_TUPLES + 1);

  logic [CW-1:0] cnt;

  assign at_limit = (cnt == CW'(MAX_TUPLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (bump && !at_limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_dest_collect.sv
// Gathers the little-endian destination bytes of a long-link tuple.
module tw_dest_collect #(
  parameter int AW = 16,
  localparam int DB = (AW + 7) / 8,
  localparam int IW = (DB > 1) ? $clog2(DB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] dest
);
  logic [DB*8-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < DB; i++) begin
        if (idx == IW'(i)) raw[i*8 +: 8] <= byte_in;
      end
    end
  end

  assign dest = raw[AW-1:0];
endmodule

// File: rtl/tuple_walker.sv
module tuple_walker
  import twalk_pkg::*;
#(
  parameter int AW         = 16,
  parameter int MAX_TUPLES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          link_err,
  output logic          limit_err,
  output logic          rd_req_valid,
  output logic [AW-1:0] rd_req_addr,
  output logic          rd_req_common,
  input  logic          rd_rsp_valid,
  input  logic [7:0]    rd_rsp_data,
  output logic          tup_valid,
  input  logic          tup_ready,
  output logic [7:0]    tup_code,
  output logic [7:0]    tup_link,
  output logic [AW-1:0] tup_addr,
  output logic          tup_common
);
  localparam int DB = (AW + 7) / 8;
  localparam int IW = (DB > 1) ? $clog2(DB) : 1;

  walk_state_e   st;
  logic [AW-1:0] cur_addr;
  logic          cur_common;
  logic [7:0]    code_q;
  logic [7:0]    link_q;
  logic          saw_nolink;
  logic          saw_ll;
  logic          ll_common;
  logic          expect_target;
  logic          jump_explicit;
  logic [IW-1:0] dest_idx;
  logic          done_q, link_err_q, limit_err_q;

  logic          rsp_take;
  logic [8:0]    rd_off, nxt_off;
  logic [AW-1:0] rd_addr, nxt_addr;
  logic [AW-1:0] dest_raw, dest_eff;
  logic          at_limit;
  logic          target_miss;
  logic          chain_end;
  logic          is_ll;

  assign rsp_take = rd_req_valid && rd_rsp_valid;
  assign is_ll    = (code_q == TC_LL_ATTR) || (code_q == TC_LL_COM);

  always_comb begin
    case (st)
      ST_LINK: rd_off = 9'd1;
      ST_DEST: rd_off = 9'd2 + 9'(dest_idx);
      default: rd_off = 9'd0;
    endcase
  end

  // in the code phase only a null tuple advances: one byte position
  assign nxt_off = (st == ST_CODE) ? 9'd1 : 9'd2 + {1'b0, link_q};

  tw_addr_step #(.AW(AW)) u_rd_step (
    .base(cur_addr), .is_common(cur_common), .off(rd_off), .addr(rd_addr)
  );

  tw_addr_step #(.AW(AW)) u_nxt_step (
    .base(cur_addr), .is_common(cur_common), .off(nxt_off), .addr(nxt_addr)
  );

  tw_visit_guard #(.MAX_TUPLES(MAX_TUPLES)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .clear(st == ST_IDLE && start),
    .bump(st == ST_CODE && rsp_take),
    .at_limit(at_limit)
  );

  tw_dest_collect #(.AW(AW)) u_dest (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st == ST_DEST && rsp_take),
    .idx(dest_idx), .byte_in(rd_rsp_data), .dest(dest_raw)
  );

  assign dest_eff = ll_common ? dest_raw : {dest_raw[AW-1:1], 1'b0};

  assign target_miss = expect_target && (rd_rsp_data != TC_TARGET);

  assign chain_end =
      (st == ST_CODE && rsp_take && !at_limit && !target_miss && rd_rsp_data == TC_END) ||
      (st == ST_LINK && rsp_take && rd_rsp_data == LINK_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      cur_addr      <= '0;
      cur_common    <= 1'b0;
      code_q        <= '0;
      link_q        <= '0;
      saw_nolink    <= 1'b0;
      saw_ll        <= 1'b0;
      ll_common     <= 1'b0;
      expect_target <= 1'b0;
      jump_explicit <= 1'b0;
      dest_idx      <= '0;
      done_q        <= 1'b0;
      link_err_q    <= 1'b0;
      limit_err_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st            <= ST_CODE;
            cur_addr      <= '0;
            cur_common    <= 1'b0;
            saw_nolink    <= 1'b0;
            saw_ll        <= 1'b0;
            expect_target <= 1'b0;
            jump_explicit <= 1'b0;
            done_q        <= 1'b0;
            link_err_q    <= 1'b0;
            limit_err_q   <= 1'b0;
          end
        end
        ST_CODE: begin
          if (rsp_take) begin
            if (at_limit) begin
              limit_err_q <= 1'b1;
              done_q      <= 1'b1;
              st          <= ST_IDLE;
            end else if (target_miss) begin
              link_err_q <= jump_explicit;
              done_q     <= 1'b1;
              st         <= ST_IDLE;
            end else begin
              expect_target <= 1'b0;
              code_q        <= rd_rsp_data;
              if (rd_rsp_data == TC_NULL) cur_addr <= nxt_addr;
              else if (rd_rsp_data != TC_END) st <= ST_LINK;
            end
          end
        end
        ST_LINK: begin
          if (rsp_take) begin
            link_q <= rd_rsp_data;
            if (rd_rsp_data != LINK_END) st <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tup_ready) begin
            if (code_q == TC_NOLINK) saw_nolink <= 1'b1;
            if (is_ll) begin
              saw_ll    <= 1'b1;
              ll_common <= (code_q == TC_LL_COM);
              dest_idx  <= '0;
              st        <= ST_DEST;
            end else begin
              cur_addr <= nxt_addr;
              st       <= ST_CODE;
            end
          end
        end
        ST_DEST: begin
          if (rsp_take) begin
            if (dest_idx == IW'(DB - 1)) begin
              cur_addr <= nxt_addr;
              st       <= ST_CODE;
            end else begin
              dest_idx <= dest_idx + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase

      // end of one chain: finish, follow the long link, or take the implied jump
      if (chain_end) begin
        if (!saw_nolink && saw_ll) begin
          cur_addr      <= dest_eff;
          cur_common    <= ll_common;
          expect_target <= 1'b1;
          jump_explicit <= 1'b1;
          saw_ll        <= 1'b0;
          st            <= ST_CODE;
        end else if (!saw_nolink && !cur_common) begin
          cur_addr      <= '0;
          cur_common    <= 1'b1;
          expect_target <= 1'b1;
          jump_explicit <= 1'b0;
          st            <= ST_CODE;
        end else begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
      end
    end
  end

  assign busy          = (st != ST_IDLE);
  assign done          = done_q;
  assign link_err      = link_err_q;
  assign limit_err     = limit_err_q;
  assign rd_req_valid  = (st == ST_CODE) || (st == ST_LINK) || (st == ST_DEST);
  assign rd_req_addr   = rd_addr;
  assign rd_req_common = cur_common;
  assign tup_valid     = (st == ST_SEND);
  assign tup_code      = code_q;
  assign tup_link      = link_q;
  assign tup_addr      = cur_addr;
  assign tup_common    = cur_common;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          link_err,
  input logic          limit_err,
  input logic          rd_req_valid,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_req_common,
  input logic          rd_rsp_valid,
  input logic          tup_valid,
  input logic          tup_ready,
  input logic [7:0]    tup_code,
  input logic [7:0]    tup_link,
  input logic [AW-1:0] tup_addr,
  input logic          tup_common
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !tup_valid));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_rsp_valid) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_common)));

  a_r3_attr_even: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_common) |-> !rd_req_addr[0]);

  a_r5_tup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tup_valid && !tup_ready) |=>
      (tup_valid && $stable(tup_code) && $stable(tup_link) &&
       $stable(tup_addr) && $stable(tup_common)));

  a_r5_no_read_while_offering: assert property (@(posedge clk) disable iff (!rst_n)
    tup_valid |-> !rd_req_valid);

  a_r13_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (link_err || limit_err) |-> (done && !busy));

  a_r13_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_err, limit_err}));

  a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind tuple_walker tw_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .link_err(link_err), .limit_err(limit_err),
  .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
  .rd_req_common(rd_req_common), .rd_rsp_valid(rd_rsp_valid),
  .tup_valid(tup_valid), .tup_ready(tup_ready), .tup_code(tup_code),
  .tup_link(tup_link), .tup_addr(tup_addr), .tup_common(tup_common)
);

// File: tb/tb_tuple_walker.sv
`timescale 1ns/1ps
module tb_tuple_walker;
  localparam int AW = 10;
  localparam int MAXT = 12;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, link_err, limit_err;
  logic rd_req_valid, rd_req_common, rd_rsp_valid = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic [7:0] rd_rsp_data = 8'h00;
  logic tup_valid, tup_ready = 1'b0, tup_common;
  logic [7:0] tup_code, tup_link;
  logic [AW-1:0] tup_addr;

  always #2.5 clk = ~clk;

  tuple_walker #(.AW(AW), .MAX_TUPLES(MAXT)) dut (.*);

  logic [7:0] amem [MSZ];
  logic [7:0] cmem [MSZ];
  int acur, ccur;
  int exp_code [64], exp_link [64], exp_addr [64], exp_com [64], exp_n;
  int got_code [64], got_link [64], got_addr [64], got_com [64], got_n;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat_mode = 0, rdy_mode = 0, wait_cnt = 0;
  int req_bad = 0, tup_bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic p_req = 0, p_take = 0, p_tv = 0, p_tr = 0;
  logic [AW-1:0] p_addr = '0, p_taddr = '0;
  logic [7:0] p_tcode = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model, back-pressure, capture and port-level hold monitors
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      rd_rsp_valid = 0; wait_cnt = 0; tup_ready = 0;
      p_req = 0; p_tv = 0;
    end else begin
      if (p_req && !p_take && (!rd_req_valid || rd_req_addr != p_addr)) req_bad++;
      if (p_tv && !p_tr && (!tup_valid || tup_code != p_tcode || tup_addr != p_taddr)) tup_bad++;
      if (rd_rsp_valid) begin
        rd_rsp_valid = 0; wait_cnt = 0;
      end else if (rd_req_valid) begin
        if (lat_mode == 0 || wait_cnt >= int'(lfsr[1:0])) begin
          rd_rsp_valid = 1;
          rd_rsp_data = rd_req_common ? cmem[rd_req_addr] : amem[rd_req_addr];
        end else wait_cnt++;
      end
      tup_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[4] | lfsr[9]);
      if (tup_valid && tup_ready && got_n < 64) begin
        got_code[got_n] = tup_code; got_link[got_n] = tup_link;
        got_addr[got_n] = tup_addr; got_com[got_n] = tup_common;
        got_n++;
      end
      p_req = rd_req_valid; p_take = rd_rsp_valid; p_addr = rd_req_addr;
      p_tv = tup_valid; p_tr = tup_ready; p_tcode = tup_code; p_taddr = tup_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic clear_img();
    for (int i = 0; i < MSZ; i++) begin amem[i] = 8'hFF; cmem[i] = 8'hFF; end
    acur = 0; ccur = 0; exp_n = 0;
  endtask

  task automatic wr(input bit com, input int a, input logic [7:0] v);
    if (com) cmem[a] = v; else amem[a] = v;
  endtask

  task automatic note(input bit com, input int code, input int link, input int a);
    exp_code[exp_n] = code; exp_link[exp_n] = link;
    exp_addr[exp_n] = a; exp_com[exp_n] = com; exp_n++;
  endtask

  // tuple with filler body; reported when rep is set
  task automatic put_t(input bit com, input int code, input int link, input bit rep);
    int b, s;
    b = com ? ccur : acur; s = com ? 1 : 2;
    wr(com, b, code[7:0]); wr(com, b + s, link[7:0]);
    for (int k = 0; k < link; k++) wr(com, b + s * (2 + k), 8'h40 + k[7:0]);
    if (rep) note(com, code, link, b);
    if (com) ccur = b + 2 + link; else acur = b + 2 * (2 + link);
  endtask

  task automatic put_ll(input bit com, input int code, input int dest, input bit rep);
    int b, s;
    b = com ? ccur : acur; s = com ? 1 : 2;
    wr(com, b, code[7:0]); wr(com, b + s, 8'd4);
    wr(com, b + 2 * s, dest[7:0]); wr(com, b + 3 * s, dest[15:8]);
    wr(com, b + 4 * s, 8'h00); wr(com, b + 5 * s, 8'h00);
    if (rep) note(com, code, 4, b);
    if (com) ccur = b + 6; else acur = b + 12;
  endtask

  task automatic put_null(input bit com);
    if (com) begin cmem[ccur] = 8'h00; ccur++; end
    else begin amem[acur] = 8'h00; acur += 2; end
  endtask

  task automatic put_end(input bit com);
    if (com) cmem[ccur] = 8'hFF; else amem[acur] = 8'hFF;
  endtask

  task automatic run_walk(input int restart_at);
    int t;
    got_n = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk); t++;
      if (t == restart_at) begin
        chk("R1 busy mid-walk", busy, 1);
        start = 1;
        @(negedge clk) start = 0;
      end
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: walk never finished actual=0 expected=1");
    end
  endtask

  task automatic cmp_list(input string tag);
    chk({tag, " report count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk({tag, " code"}, got_code[i], exp_code[i]);
      chk({tag, " link"}, got_link[i], exp_link[i]);
      chk({tag, " addr"}, got_addr[i], exp_addr[i]);
      chk({tag, " space"}, got_com[i], exp_com[i]);
    end
  endtask

  task automatic cmp_end(input string tag, input int de, input int le, input int me);
    chk({tag, " done"}, done, de);
    chk({tag, " link_err"}, link_err, le);
    chk({tag, " limit_err"}, limit_err, me);
    chk({tag, " busy"}, busy, 0);
  endtask

  initial begin
    clear_img();
    repeat (4) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset errors", {link_err, limit_err}, 0);
    chk("R1 reset no request", rd_req_valid, 0);
    chk("R1 reset no report", tup_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R6 R8: nulls, even addressing, no-link beats long-link
    clear_img();
    put_null(0); put_t(0, 8'h20, 3, 1); put_null(0);
    put_t(0, 8'h14, 0, 1); put_t(0, 8'h21, 1, 1);
    put_ll(0, 8'h11, 16'h200, 1); put_end(0);
    acur = 16'h200; put_t(0, 8'h13, 0, 0); put_t(0, 8'h30, 2, 0); put_end(0);
    lat_mode = 0; rdy_mode = 0;
    run_walk(0);
    cmp_list("R3 R6 R8 nulls/no-link");
    cmp_end("R8 no-link end", 1, 0, 0);

    // R4 R10 sweep: attribute chain, implied jump, common chain
    for (int L = 0; L < 8; L++) begin
      clear_img();
      put_t(0, 8'h22, L, 1); put_t(0, 8'h23, 7 - L, 1); put_end(0);
      put_t(1, 8'h13, 3, 1); put_t(1, 8'h24, L, 1); put_t(1, 8'h25, 2 * L, 1); put_end(1);
      lat_mode = L % 2; rdy_mode = (L / 2) % 2;
      run_walk(L == 3 ? 6 : 0);
      cmp_list("R4 R10 sweep");
      cmp_end("R10 common chain end", 1, 0, 0);
    end
    chk("R2 request held until response", req_bad, 0);
    chk("R5 report held under back-pressure", tup_bad, 0);

    // R10 R11: implied jump without link target ends quietly
    clear_img();
    put_t(0, 8'h26, 2, 1); put_end(0);
    put_t(1, 8'h27, 1, 0); put_end(1);
    lat_mode = 1; rdy_mode = 1;
    run_walk(0);
    cmp_list("R11 implied miss");
    cmp_end("R11 implied miss quiet", 1, 0, 0);

    // R9 R11: long-link into attribute space, odd destination forced even
    clear_img();
    put_ll(0, 8'h11, 16'h101, 1); put_t(0, 8'h28, 0, 1); put_end(0);
    acur = 16'h100;
    put_t(0, 8'h13, 3, 1); put_t(0, 8'h29, 5, 1); put_t(0, 8'h14, 0, 1); put_end(0);
    lat_mode = 1; rdy_mode = 0;
    run_walk(0);
    cmp_list("R9 attr long-link");
    cmp_end("R9 attr long-link", 1, 0, 0);

    // R9 R11: long-link into common space landing on a wrong code
    clear_img();
    put_ll(0, 8'h12, 16'h040, 1); put_end(0);
    put_t(1, 8'h13, 0, 0); put_end(1);
    ccur = 16'h040; put_t(1, 8'h2A, 1, 0); put_end(1);
    lat_mode = 0; rdy_mode = 1;
    run_walk(0);
    cmp_list("R11 explicit miss");
    cmp_end("R11 explicit miss", 1, 1, 0);

    // R7: link byte FFh ends the chain and is not reported
    clear_img();
    put_t(0, 8'h2B, 2, 1);
    amem[acur] = 8'h2C; amem[acur + 2] = 8'hFF;
    lat_mode = 1; rdy_mode = 1;
    run_walk(0);
    cmp_list("R7 link FF");
    cmp_end("R7 link FF", 1, 0, 0);

    // R12: looping chain stopped by the tuple limit
    clear_img();
    put_ll(0, 8'h11, 16'h010, 1); put_end(0);
    acur = 16'h010; put_t(0, 8'h13, 0, 0); put_ll(0, 8'h11, 16'h010, 0); put_end(0);
    lat_mode = 0; rdy_mode = 0;
    run_walk(0);
    chk("R12 reports before limit", got_n, 8);
    cmp_end("R12 limit", 1, 0, 1);

    // R13: flags sticky while idle, cleared by the next start
    repeat (5) @(negedge clk);
    chk("R13 limit_err sticky", limit_err, 1);
    chk("R13 done sticky", done, 1);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R13 done cleared by start", done, 0);
    chk("R13 limit_err cleared by start", limit_err, 0);
    chk("R1 busy after start", busy, 1);
    while (!done) @(negedge clk);
    chk("R12 limit again", limit_err, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule